// File: doc/BRIEF.md
# Masked-Write Pin Control Register

This block is one 32-bit register on a simple single-cycle register bus. It owns two general-purpose pins that together form the clock and data lines of a monitor serial link. Pin 0 is the clock line and pin 1 is the data line. For each pin the register stores a direction and an output value. It also holds a captured copy of the pin's input. Software changes a stored field only by setting that field's companion mask bit in the same write. One pin can therefore be retimed without a read-modify-write, and the other pin is left as it is.

The pin inputs are not sampled all the time. Each raw input first passes through a two-flop synchronizer. The synchronized value is latched into the register's input bit only when a write to this register has the byte enable of that pin's byte set. Software that wants a current input level issues a dummy write to the byte, which may carry all mask bits clear, and then reads. A read returns the whole word one cycle after the read strobe.

Top module: `gpio_mask_reg`

## Requirements
- R1: After reset `pin_oe` is 00, `pin_out` is 00 and `bus_rdata` is 0. Every stored direction and data bit is 0. The input bits (bits 4 and 12) are unspecified until the first write to their byte.
- R2: Pin i's stored data value takes write-data bit 8i+3 only when write-data bit 8i+2 (data mask) is 1 in that same accepted write. Otherwise the stored data value keeps its previous value.
- R3: Pin i's stored direction takes write-data bit 8i+1 only when write-data bit 8i (direction mask) is 1 in that same accepted write. Otherwise the stored direction keeps its previous value.
- R4: `pin_oe[i]` equals pin i's stored direction: 1 means output and 0 means input. A write that changes it shows on the port in the cycle after the write edge.
- R5: `pin_out[i]` carries pin i's stored data value while `pin_oe[i]` is 1, and is 0 while `pin_oe[i]` is 0.
- R6: Input bit 8i+4 is loaded only at an accepted write with `bus_be[i]` set. It loads the value `pin_in[i]` held two rising edges before that write edge, which is the two-flop synchronizer output. Between such writes the bit holds its value.
- R7: A read at the register address returns, on the edge after the strobe, the word with pin i's field at bits 8i+4..8i: bit 8i+4 is the input, 8i+3 the data value and 8i+1 the direction. Both mask bits and all reserved bits (31:13 and 7:5) read 0. When no matching read is strobed, `bus_rdata` is 0.
- R8: An accepted write with `bus_be[i]` clear changes neither field of pin i and does not trigger its input capture.
- R9: A write to any address other than 0x5010 changes nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte enables of the write; lane i is pin i |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the strobe |
| pin_out | output | 2 | Pin output values: bit 0 clock line, bit 1 data line |
| pin_oe | output | 2 | Pin output enables, 1 = drive |
| pin_in | input | 2 | Raw pin input levels, asynchronous |

## Verification
Direction and data changes appear on `pin_oe` and `pin_out` one edge after the write. Read data appears one edge after the read strobe, and the captured input reflects `pin_in` as it stood two edges before the capturing write. The bench drives every access at a falling edge and compares a behavioural model against all outputs at the next falling edge. That model keeps its own two-deep history of the pins, so each result is checked in the cycle it is due. Directed checks cover each of these offsets. Among them, an input change made in the very cycle of a write must not yet be captured.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   // Bit positions inside one pin's byte lane; software decodes these.
   localparam int LANE_W       = 8;
   localparam int FLD_W        = 5;
   localparam int POS_DIR_MASK = 0;
   localparam int POS_DIR_VAL  = 1;
   localparam int POS_DAT_MASK = 2;
   localparam int POS_DAT_VAL  = 3;
   localparam int POS_DAT_IN   = 4;

   // Packed MSB first so the member order matches the positions above.
   typedef struct packed {
      logic dat_in;
      logic dat_val;
      logic dat_mask;
      logic dir_val;
      logic dir_mask;
   } pin_fld_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_field.sv
module gpio_pin_field
   import gpio_mask_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  pin_fld_t wr_fld,
   input  logic     pin_raw,
   output logic     pin_out,
   output logic     pin_oe,
   output pin_fld_t rd_fld
);

   logic dir_q;
   logic dat_q;
   logic cap_q;
   logic pin_sync;

   gpio_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_raw),
      .dout  (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
         dat_q <= 1'b0;
         cap_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_fld.dir_mask) dir_q <= wr_fld.dir_val;
         if (wr_fld.dat_mask) dat_q <= wr_fld.dat_val;
         cap_q <= pin_sync;
      end
   end

   assign pin_oe  = dir_q;
   assign pin_out = dir_q & dat_q;

   always_comb begin
      rd_fld          = '0;
      rd_fld.dat_in   = cap_q;
      rd_fld.dat_val  = dat_q;
      rd_fld.dir_val  = dir_q;
   end

   logic unused_wr_in;
   assign unused_wr_in = wr_fld.dat_in;

   AST_DIR_KEPT:  assert property (@(posedge clk) disable iff (!rst_n)
                     !(wr_en && wr_fld.dir_mask) |=> $stable(pin_oe));          // R3
   AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                     !(wr_en && wr_fld.dat_mask) |=> $stable(rd_fld.dat_val));  // R2
   AST_CAP_KEPT:  assert property (@(posedge clk) disable iff (!rst_n)
                     !wr_en |=> $stable(rd_fld.dat_in));                        // R6
   AST_IDLE_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
                     !pin_oe |-> !pin_out);                                     // R5

endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
   import gpio_mask_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] REG_OFFSET  = 16'h5010,
   parameter int                DATA_W      = 32,
   parameter int                NUM_PINS    = 2,
   parameter int                SYNC_STAGES = 2,
   localparam int               BE_W        = DATA_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [BE_W-1:0]     bus_be,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_rd,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic [NUM_PINS-1:0] pin_in
);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("gpio_mask_reg: DATA_W must be a whole number of bytes");
   end
   if (NUM_PINS < 1 || NUM_PINS > BE_W) begin : g_bad_pins
      $error("gpio_mask_reg: one byte lane per pin is required");
   end

   logic     hit;
   logic     wr_hit;
   pin_fld_t fld_rd [NUM_PINS];
   logic [DATA_W-1:0] rd_word;

   assign hit    = (bus_addr == REG_OFFSET);
   assign wr_hit = bus_wr && hit;

   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      gpio_pin_field #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_fld (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_hit && bus_be[gi]),
         .wr_fld  (pin_fld_t'(bus_wdata[gi*LANE_W +: FLD_W])),
         .pin_raw (pin_in[gi]),
         .pin_out (pin_out[gi]),
         .pin_oe  (pin_oe[gi]),
         .rd_fld  (fld_rd[gi])
      );
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         rd_word[i*LANE_W +: FLD_W] = fld_rd[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= (bus_rd && hit) ? rd_word : '0;
   end

   logic unused_bus;
   assign unused_bus = ^{bus_wdata, bus_be};

   AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                        (bus_rd && !hit) |=> (bus_rdata == '0));                // R9
   AST_WR_MISS_OE:   assert property (@(posedge clk) disable iff (!rst_n)
                        (bus_wr && !hit) |=> $stable(pin_oe));                  // R9
   AST_NO_RD_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
                        !bus_rd |=> (bus_rdata == '0));                         // R7
   AST_LANE_OFF:     assert property (@(posedge clk) disable iff (!rst_n)
                        (bus_wr && !bus_be[0]) |=> $stable(pin_oe[0]));         // R8

endmodule

// File: tb/gpio_mask_reg_bench.sv
module gpio_mask_reg_bench;

   localparam logic [15:0] A_REG = 16'h5010;
   localparam logic [15:0] A_BAD = 16'h5014;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = A_REG;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [1:0]  pin_out;
   logic [1:0]  pin_oe;
   logic [1:0]  pin_in = 2'b00;

   int tests = 0;
   int fails = 0;

   always #2ns clk = ~clk;

   gpio_mask_reg u_gpio_mask_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .pin_in    (pin_in)
   );

   // Behavioural reference, updated at each rising edge.
   bit   m_dir [2];
   bit   m_dat [2];
   bit   m_cap [2];
   bit   m_capv [2];
   bit   m_hist [2][$];
   logic [31:0] m_rdata = 32'h0;
   logic [31:0] m_rmask = 32'hFFFF_FFFF;

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_hist[i] = '{1'b0, 1'b0};
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_dir[i] = 0; m_dat[i] = 0; m_cap[i] = 0; m_capv[i] = 0;
            m_hist[i] = '{1'b0, 1'b0};
         end
         m_rdata = 0;
         m_rmask = 32'hFFFF_FFFF;
      end else begin
         logic [31:0] w;
         w = 0;
         m_rmask = 32'hFFFF_FFFF;
         for (int i = 0; i < 2; i++) begin
            w[8*i+4] = m_cap[i];
            w[8*i+3] = m_dat[i];
            w[8*i+1] = m_dir[i];
            if (!m_capv[i]) m_rmask[8*i+4] = 1'b0;
         end
         m_rdata = (bus_rd && bus_addr == A_REG) ? w : 32'h0;
         if (bus_wr && bus_addr == A_REG) begin
            for (int i = 0; i < 2; i++) begin
               if (bus_be[i]) begin
                  if (bus_wdata[8*i])   m_dir[i] = bus_wdata[8*i+1];
                  if (bus_wdata[8*i+2]) m_dat[i] = bus_wdata[8*i+3];
                  m_cap[i]  = m_hist[i][0];
                  m_capv[i] = 1;
               end
            end
         end
         for (int i = 0; i < 2; i++) begin
            void'(m_hist[i].pop_front());
            m_hist[i].push_back(pin_in[i]);
         end
      end
   end

   // Cycle-by-cycle comparison at every falling edge.
   always @(negedge clk) begin
      for (int i = 0; i < 2; i++) begin
         tests++;
         if (pin_oe[i] !== m_dir[i]) begin
            fails++;
            $display("FAIL R4 pin_oe[%0d] got %b exp %b", i, pin_oe[i], m_dir[i]);
         end
         tests++;
         if (pin_out[i] !== (m_dir[i] & m_dat[i])) begin
            fails++;
            $display("FAIL R5 pin_out[%0d] got %b exp %b", i, pin_out[i], m_dir[i] & m_dat[i]);
         end
      end
      tests++;
      if ((bus_rdata & m_rmask) !== (m_rdata & m_rmask)) begin
         fails++;
         $display("FAIL R7 bus_rdata got %h exp %h", bus_rdata & m_rmask, m_rdata & m_rmask);
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 4'h0; bus_addr = A_REG;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] v);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = A_REG;
      v = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #100us;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] lfsr;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      check("R1 pin_oe", {30'h0, pin_oe}, 32'h0);
      check("R1 pin_out", {30'h0, pin_out}, 32'h0);
      check("R1 rdata idle", bus_rdata, 32'h0);
      rd(A_REG, v);
      check("R1 read stored bits", v & ~32'h0000_1010, 32'h0);

      // R2 R3 R4 R5: pin0 dir+data with masks, pin1 dir only (data mask clear)
      wr(A_REG, 4'h3, 32'h0000_0B0F);
      check("R4 both outputs", {30'h0, pin_oe}, 32'h3);
      check("R2 pin1 data kept", {30'h0, pin_out}, 32'h1);

      // R2: data values without masks change nothing
      wr(A_REG, 4'h3, 32'h0000_0808);
      check("R2 no mask no change", {30'h0, pin_out}, 32'h1);
      wr(A_REG, 4'h3, 32'h0000_0C00);
      check("R5 pin1 driven high", {30'h0, pin_out}, 32'h3);

      // R3: direction value without its mask is ignored
      wr(A_REG, 4'h3, 32'h0000_0000);
      check("R3 dir kept", {30'h0, pin_oe}, 32'h3);
      wr(A_REG, 4'h1, 32'h0000_0001);
      check("R4 pin0 input", {30'h0, pin_oe}, 32'h2);
      check("R5 pin0 not driven", {30'h0, pin_out}, 32'h2);

      // R7: word layout, masks and reserved read 0, inputs were 0
      rd(A_REG, v);
      check("R7 word", v, 32'h0000_0A08);
      idle(1);
      check("R7 idle after read", bus_rdata, 32'h0);

      // R6 R8: capture only in enabled lane, other lane untouched
      pin_in = 2'b11;
      idle(3);
      wr(A_REG, 4'h1, 32'h0000_0100);
      check("R8 pin1 dir kept", {30'h0, pin_oe}, 32'h2);
      rd(A_REG, v);
      check("R6 R8 capture lane0 only", v, 32'h0000_0A18);

      // R9: foreign address
      wr(A_BAD, 4'hF, 32'h0000_0101);
      check("R9 write ignored", {30'h0, pin_oe}, 32'h2);
      rd(A_BAD, v);
      check("R9 read zero", v, 32'h0);

      // R6: synchronizer latency, change made in the cycle of the write
      wr(A_REG, 4'h3, 32'h0);
      rd(A_REG, v);
      check("R6 both captured", v, 32'h0000_1A18);
      pin_in = 2'b00;
      wr(A_REG, 4'h3, 32'h0);
      rd(A_REG, v);
      check("R6 old value captured", v, 32'h0000_1A18);
      idle(3);
      wr(A_REG, 4'h3, 32'h0);
      rd(A_REG, v);
      check("R6 new value captured", v, 32'h0000_0A08);

      // Mixed traffic, compared against the model every cycle (R2 R3 R6 R8)
      lfsr = 32'hACE1_1234;
      for (int n = 0; n < 200; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         pin_in = lfsr[9:8];
         case (lfsr[3:2])
            2'd0: wr(A_REG, lfsr[7:4], lfsr);
            2'd1: rd(A_REG, v);
            2'd2: wr(lfsr[0] ? A_BAD : A_REG, 4'hF, {lfsr[15:0], lfsr[31:16]});
            default: idle(1);
         endcase
      end

      idle(2);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule